// File: doc/BRIEF.md
# Register Status Rename Table

This block keeps the architectural register file together with one pending-producer tag per register, for use at the in-order issue stage of a machine that schedules operations dynamically. When an operation issues, each of its two source registers is looked up. If no producer is pending, the source comes back as a ready value. If a producer is pending, the source comes back as that producer's station tag, and the consumer waits for it. In the same step, the destination register is claimed by the newly allocated station tag.

Results come back over a single broadcast bus that carries a tag and a value. A register takes the broadcast value only while its pending tag still equals the broadcast tag, and then becomes free. When several producers target one register, only the youngest one can update it, so write-after-write and write-after-read hazards between in-flight operations need no checking. A broadcast that arrives in the same cycle as a source lookup is forwarded straight to the lookup result.

Tag value 0 is reserved to mean "no pending producer". Station allocation and the execution units sit outside this block.

Top module: `reg_status_table`

## Requirements
- R1: After reset, every register holds value 0 and has no pending producer, so every source lookup returns ready with value 0 and tag 0.
- R2: A source whose register has no pending producer returns ready=1, the register value, and tag 0.
- R3: A source whose register has a pending tag, with no matching broadcast in that cycle, returns ready=0, value 0, and the pending tag.
- R4: An issue (valid with a nonzero tag; tag 0 is never issued) sets the destination register's pending tag to the issue tag from the next cycle on.
- R5: A broadcast whose tag equals a register's nonzero pending tag writes the broadcast value into that register and clears the pending tag from the next cycle on.
- R6: A broadcast whose tag differs from a register's pending tag leaves that register's value and pending tag unchanged.
- R7: After two issues to the same register, a broadcast carrying the older tag does not update the register; only the younger tag's broadcast does.
- R8: When an issue names the same register as source and destination, the source lookup in that cycle reflects the state before the issue.
- R9: When an issue and a broadcast matching the old pending tag hit the same register in one cycle, the register keeps its old value and holds the new issue tag.
- R10: A source lookup whose pending tag matches a broadcast in the same cycle returns ready=1, the broadcast value, and tag 0.
- R11: A broadcast carrying tag 0 changes no register and forwards to no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request this cycle |
| iss_src_a_i | input | IDX_W | First source register index |
| iss_src_b_i | input | IDX_W | Second source register index |
| iss_dst_i | input | IDX_W | Destination register index |
| iss_tag_i | input | TAG_W | Newly allocated station tag, nonzero |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Tag of the broadcasting station |
| bc_data_i | input | DATA_W | Broadcast result value |
| src_a_rdy_o | output | 1 | First source holds a value |
| src_a_val_o | output | DATA_W | First source value when ready, else 0 |
| src_a_tag_o | output | TAG_W | First source producer tag when not ready, else 0 |
| src_b_rdy_o | output | 1 | Second source holds a value |
| src_b_val_o | output | DATA_W | Second source value when ready, else 0 |
| src_b_tag_o | output | TAG_W | Second source producer tag when not ready, else 0 |

## Verification
Lookups are tried against free registers, pending registers, and registers whose producer broadcasts in the same cycle. This separates the register path, the tag path and the forwarding path. Broadcasts are sent with a matching tag, a stale older tag after a second issue to the same register, an unrelated tag, and tag 0. Only the matching tag may change state. Issues that rename their own source, and issues that meet a broadcast on the same register in one cycle, show whether lookup precedes claim and whether the new claim wins over the stale result. A mid-run reset shows that values and claims are both cleared.

// File: rtl/rst_pkg.sv
`timescale 1ns/1ps
package rst_pkg;
  localparam int unsigned DEF_NUM_REGS = 4;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_TAG_W    = 4;

  typedef enum logic [1:0] {
    SRC_REG    = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_WAIT   = 2'd2
  } src_sel_e;
endpackage

// File: rtl/rst_status_entry.sv
`timescale 1ns/1ps
module rst_status_entry #(
  parameter int unsigned DATA_W = rst_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W  = rst_pkg::DEF_TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_hit_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic [TAG_W-1:0]  qi_o,
  output logic [DATA_W-1:0] val_o
);
  logic [TAG_W-1:0]  qi_q;
  logic [DATA_W-1:0] val_q;
  logic              bc_hit;

  // tag 0 means free; never matched
  assign bc_hit = bc_valid_i && (qi_q != '0) && (qi_q == bc_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qi_q  <= '0;
      val_q <= '0;
    end else if (iss_hit_i) begin
      qi_q <= iss_tag_i;       // new claim beats stale result
    end else if (bc_hit) begin
      qi_q  <= '0;
      val_q <= bc_data_i;
    end
  end

  assign qi_o  = qi_q;
  assign val_o = val_q;

  AST_ISSUE_CLAIMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_hit_i |=> (qi_o == $past(iss_tag_i))); // R4
  AST_BCAST_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iss_hit_i && bc_valid_i && qi_o != '0 && bc_tag_i == qi_o)
      |=> (qi_o == '0 && val_o == $past(bc_data_i))); // R5
  AST_MISS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iss_hit_i && !(bc_valid_i && bc_tag_i == qi_o))
      |=> ($stable(qi_o) && $stable(val_o))); // R6
  AST_FREE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iss_hit_i && qi_o == '0) |=> (qi_o == '0 && $stable(val_o))); // R11
  AST_ISSUE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_hit_i && bc_valid_i && bc_tag_i == qi_o)
      |=> (qi_o == $past(iss_tag_i) && $stable(val_o))); // R9
endmodule

// File: rtl/rst_src_read.sv
`timescale 1ns/1ps
module rst_src_read #(
  parameter int unsigned NUM_REGS = rst_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rst_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rst_pkg::DEF_TAG_W,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  qi_i  [NUM_REGS],
  input  logic [DATA_W-1:0] val_i [NUM_REGS],
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] val_o,
  output logic [TAG_W-1:0]  tag_o
);
  import rst_pkg::*;

  logic [TAG_W-1:0] cur_qi;
  src_sel_e         sel;

  always_comb begin
    cur_qi = qi_i[idx_i];
    if (cur_qi == '0)                         sel = SRC_REG;
    else if (bc_valid_i && bc_tag_i == cur_qi) sel = SRC_BYPASS;
    else                                      sel = SRC_WAIT;
  end

  always_comb begin
    rdy_o = 1'b1;
    val_o = '0;
    tag_o = '0;
    unique case (sel)
      SRC_REG:    val_o = val_i[idx_i];
      SRC_BYPASS: val_o = bc_data_i;
      default: begin
        rdy_o = 1'b0;
        tag_o = cur_qi;
      end
    endcase
  end
endmodule

// File: rtl/reg_status_table.sv
`timescale 1ns/1ps
module reg_status_table #(
  parameter int unsigned NUM_REGS = rst_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rst_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rst_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [IDX_W-1:0]  iss_src_a_i,
  input  logic [IDX_W-1:0]  iss_src_b_i,
  input  logic [IDX_W-1:0]  iss_dst_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              src_a_rdy_o,
  output logic [DATA_W-1:0] src_a_val_o,
  output logic [TAG_W-1:0]  src_a_tag_o,
  output logic              src_b_rdy_o,
  output logic [DATA_W-1:0] src_b_val_o,
  output logic [TAG_W-1:0]  src_b_tag_o
);
  logic [TAG_W-1:0]  qi   [NUM_REGS];
  logic [DATA_W-1:0] vals [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    rst_status_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .iss_hit_i  (iss_valid_i && (iss_dst_i == IDX_W'(g))),
      .iss_tag_i  (iss_tag_i),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_data_i  (bc_data_i),
      .qi_o       (qi[g]),
      .val_o      (vals[g])
    );
  end

  // lookups see pre-issue state (self-rename safe)
  rst_src_read #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_src_a (
    .idx_i      (iss_src_a_i),
    .qi_i       (qi),
    .val_i      (vals),
    .bc_valid_i (bc_valid_i),
    .bc_tag_i   (bc_tag_i),
    .bc_data_i  (bc_data_i),
    .rdy_o      (src_a_rdy_o),
    .val_o      (src_a_val_o),
    .tag_o      (src_a_tag_o)
  );

  rst_src_read #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_src_b (
    .idx_i      (iss_src_b_i),
    .qi_i       (qi),
    .val_i      (vals),
    .bc_valid_i (bc_valid_i),
    .bc_tag_i   (bc_tag_i),
    .bc_data_i  (bc_data_i),
    .rdy_o      (src_b_rdy_o),
    .val_o      (src_b_val_o),
    .tag_o      (src_b_tag_o)
  );

  AST_TAG_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i |-> (iss_tag_i != '0)); // R4
  AST_RDY_NO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_a_rdy_o |-> (src_a_tag_o == '0)); // R2
  AST_WAIT_HAS_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_b_rdy_o |-> (src_b_tag_o != '0 && src_b_val_o == '0)); // R3
endmodule

// File: tb/reg_status_table_tb.sv
`timescale 1ns/1ps
module reg_status_table_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned TW = 4;
  localparam int unsigned IW = 2;
  localparam int NV = 16;

  typedef struct packed {
    logic          iv;
    logic [IW-1:0] sa, sb, d;
    logic [TW-1:0] t;
    logic          bv;
    logic [TW-1:0] bt;
    logic [DW-1:0] bd;
    logic          ar;
    logic [DW-1:0] av;
    logic [TW-1:0] at;
    logic          br;
    logic [DW-1:0] bvl;
    logic [TW-1:0] btg;
  } vec_t;

  // iv sa sb d t | bv bt bd | a: rdy val tag | b: rdy val tag
  localparam vec_t VECS [NV] = '{
    '{1'b0,2'd0,2'd3,2'd0,4'd0, 1'b0,4'd0,32'h0,  1'b1,32'h0, 4'd0, 1'b1,32'h0, 4'd0}, // R1
    '{1'b1,2'd0,2'd1,2'd2,4'd5, 1'b0,4'd0,32'h0,  1'b1,32'h0, 4'd0, 1'b1,32'h0, 4'd0}, // R2 R4
    '{1'b0,2'd2,2'd1,2'd0,4'd0, 1'b1,4'd5,32'h11, 1'b1,32'h11,4'd0, 1'b1,32'h0, 4'd0}, // R10
    '{1'b0,2'd2,2'd2,2'd0,4'd0, 1'b0,4'd0,32'h0,  1'b1,32'h11,4'd0, 1'b1,32'h11,4'd0}, // R5
    '{1'b1,2'd1,2'd2,2'd1,4'd3, 1'b0,4'd0,32'h0,  1'b1,32'h0, 4'd0, 1'b1,32'h11,4'd0}, // R4
    '{1'b1,2'd1,2'd0,2'd1,4'd7, 1'b0,4'd0,32'h0,  1'b0,32'h0, 4'd3, 1'b1,32'h0, 4'd0}, // R3 R7
    '{1'b0,2'd1,2'd1,2'd0,4'd0, 1'b1,4'd3,32'h22, 1'b0,32'h0, 4'd7, 1'b0,32'h0, 4'd7}, // R7
    '{1'b0,2'd1,2'd3,2'd0,4'd0, 1'b1,4'd7,32'h33, 1'b1,32'h33,4'd0, 1'b1,32'h0, 4'd0}, // R7 R10
    '{1'b1,2'd1,2'd3,2'd1,4'd9, 1'b0,4'd0,32'h0,  1'b1,32'h33,4'd0, 1'b1,32'h0, 4'd0}, // R8
    '{1'b1,2'd1,2'd2,2'd1,4'd4, 1'b1,4'd9,32'h44, 1'b1,32'h44,4'd0, 1'b1,32'h11,4'd0}, // R9
    '{1'b0,2'd1,2'd0,2'd0,4'd0, 1'b0,4'd0,32'h0,  1'b0,32'h0, 4'd4, 1'b1,32'h0, 4'd0}, // R9
    '{1'b0,2'd1,2'd3,2'd0,4'd0, 1'b1,4'd6,32'h55, 1'b0,32'h0, 4'd4, 1'b1,32'h0, 4'd0}, // R6
    '{1'b0,2'd0,2'd3,2'd0,4'd0, 1'b1,4'd0,32'h66, 1'b1,32'h0, 4'd0, 1'b1,32'h0, 4'd0}, // R11
    '{1'b0,2'd1,2'd0,2'd0,4'd0, 1'b0,4'd0,32'h0,  1'b0,32'h0, 4'd4, 1'b1,32'h0, 4'd0}, // R6 R11
    '{1'b0,2'd1,2'd3,2'd0,4'd0, 1'b1,4'd4,32'h77, 1'b1,32'h77,4'd0, 1'b1,32'h0, 4'd0}, // R5 R10
    '{1'b0,2'd1,2'd2,2'd0,4'd0, 1'b0,4'd0,32'h0,  1'b1,32'h77,4'd0, 1'b1,32'h11,4'd0}  // R5
  };
  localparam int REQ [NV] = '{1,4,10,5,4,7,7,10,8,9,9,6,11,11,5,5};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic iss_valid_i = 1'b0, bc_valid_i = 1'b0;
  logic [IW-1:0] iss_src_a_i = '0, iss_src_b_i = '0, iss_dst_i = '0;
  logic [TW-1:0] iss_tag_i = '0, bc_tag_i = '0;
  logic [DW-1:0] bc_data_i = '0;
  logic src_a_rdy_o, src_b_rdy_o;
  logic [DW-1:0] src_a_val_o, src_b_val_o;
  logic [TW-1:0] src_a_tag_o, src_b_tag_o;
  int total = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  reg_status_table u_dut (.*);

  task automatic chk(input int req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    iss_valid_i = v.iv; iss_src_a_i = v.sa; iss_src_b_i = v.sb;
    iss_dst_i = v.d; iss_tag_i = v.t;
    bc_valid_i = v.bv; bc_tag_i = v.bt; bc_data_i = v.bd;
  endtask

  task automatic check_both(input int req, input vec_t v);
    chk(req, "a_rdy", DW'(src_a_rdy_o), DW'(v.ar));
    chk(req, "a_val", src_a_val_o, v.av);
    chk(req, "a_tag", DW'(src_a_tag_o), DW'(v.at));
    chk(req, "b_rdy", DW'(src_b_rdy_o), DW'(v.br));
    chk(req, "b_val", src_b_val_o, v.bvl);
    chk(req, "b_tag", DW'(src_b_tag_o), DW'(v.btg));
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      #2;
      check_both(REQ[i], VECS[i]);
    end
    // directed: reset clears claims and values (R1)
    @(negedge clk_i);
    drive('{1'b1,2'd0,2'd0,2'd0,4'd2, 1'b0,4'd0,32'h0, 1'b0,32'h0,4'd0, 1'b0,32'h0,4'd0});
    @(negedge clk_i);
    drive('{1'b0,2'd0,2'd1,2'd0,4'd0, 1'b0,4'd0,32'h0, 1'b0,32'h0,4'd2, 1'b1,32'h77,4'd0});
    #2;
    check_both(4, '{1'b0,2'd0,2'd1,2'd0,4'd0, 1'b0,4'd0,32'h0, 1'b0,32'h0,4'd2, 1'b1,32'h77,4'd0}); // R4
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    check_both(1, '{1'b0,2'd0,2'd1,2'd0,4'd0, 1'b0,4'd0,32'h0, 1'b1,32'h0,4'd0, 1'b1,32'h0,4'd0}); // R1
    // directed: broadcast tag 0 against free register with bypass (R11)
    @(negedge clk_i);
    drive('{1'b0,2'd2,2'd3,2'd0,4'd0, 1'b1,4'd0,32'hAB, 1'b0,32'h0,4'd0, 1'b0,32'h0,4'd0});
    #2;
    chk(11, "a_val_tag0", src_a_val_o, 32'h0); // R11
    @(negedge clk_i);
    drive('{1'b0,2'd2,2'd3,2'd0,4'd0, 1'b0,4'd0,32'h0, 1'b0,32'h0,4'd0, 1'b0,32'h0,4'd0});
    #2;
    chk(11, "b_val_after_tag0", src_b_val_o, 32'h0); // R11
    @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule